// File: doc/BRIEF.md
# Sensor limit alarm register

This block sits behind the converters of a hardware monitor. It takes 8-bit readings from several voltage channels, from one temperature channel and from two fan-speed channels. Each reading arrives with its own sample-valid strobe. The block compares each reading against limits held in a small register file and collects the results in a latched alarm status word. An external over-limit input, typically wired from a companion temperature sensor, gets its own status bit.

The last voltage input is a shared pin. A configuration bit selects whether that pin is the fifth voltage channel or the temperature channel. Voltage and fan channels work as limit comparators. The temperature channel raises an event once when the reading climbs above its maximum. It raises a second event when the reading later falls below its minimum. Status bits hold until software reads the status register. That read returns the bits and clears them. A condition that occurs in the same cycle as the read is kept for the next read.

Top module: `mon_alarm_reg`

## Requirements
- R1: After reset the status word reads 0 and the configuration register reads 0. Every voltage maximum reads 0x00FF and every voltage minimum reads 0x0000. The temperature maximum reads 0x007F, the temperature minimum reads 0x0080, and the fan limits read 0x0000.
- R2: Register map, using a 4-bit address. Voltage channel i has its maximum at 2i and its minimum at 2i+1, for addresses 0 to 9. The temperature maximum is at 10 and the temperature minimum at 11. Fan j has its limit at 12+j. The configuration register is at 14 and uses bit 0 only. The status register is at 15. Writes take effect on the clock edge at which reg_wr is sampled high. A read strobe places the addressed value, zero-extended to 16 bits, on reg_rdata one cycle later, and the value holds until the next read.
- R3: A voltage channel sets status bit i when its valid strobe is high and the unsigned code is strictly above its maximum or strictly below its minimum. A code equal to either limit sets nothing.
- R4: The temperature channel compares codes as signed two's complement values. It is active only when the configuration bit is 1, and it uses the shared input. It keeps a one-bit armed state. When the channel is not armed and a valid code is above the maximum, it sets status bit 5 and becomes armed. When the channel is armed and a valid code is below the minimum, it sets status bit 5 and disarms. Any other valid code sets nothing.
- R5: Fan channel j sets status bit 6+j when its valid strobe is high and its speed code is strictly below its limit.
- R6: Any cycle with ext_ovr high sets status bit 8.
- R7: A set status bit stays set, even after its cause has gone, until the status register is read. A read of the status register returns the current bits and clears them. A condition that occurs in the read cycle appears in the next read.
- R8: With configuration bit 0 at 0, the shared input is voltage channel 4, which drives status bit 4, and the temperature logic is disarmed and inactive. With configuration bit 0 at 1, voltage channel 4 never sets bit 4.
- R9: A reading whose valid strobe is low is not compared and sets no status bit.
- R10: A write to the status address has no effect on the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| volt_code | input | 40 | Voltage codes, channel i at bits [8i+7:8i]; channel 4 is the shared input |
| volt_vld | input | 5 | Sample-valid strobe per voltage input |
| fan_code | input | 16 | Fan speed codes, fan j at bits [8j+7:8j] |
| fan_vld | input | 2 | Sample-valid strobe per fan |
| ext_ovr | input | 1 | External over-limit indication |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 16 | Registered read data |

## Verification
The hardest case to reach from the ports is the temperature armed state, because it is never read directly. The bench steps through a fixed order of readings on the shared input. First comes a below-minimum reading while the channel is not armed. Then come an upward crossing, a repeated high reading, a fall below the minimum, and a negative code that would exceed the maximum if it were compared as unsigned. The bench also switches modes while the channel is armed, to show that the armed state clears. The other hard case is a status read in the same cycle as a new condition. The bench drives ext_ovr in the same cycle as the read strobe and then expects bit 8 in the following read.

// File: rtl/mon_alarm_pkg.sv
package mon_alarm_pkg;
    parameter int VOLT_N = 5;
    parameter int FAN_N  = 2;
    parameter int CODE_W = 8;
    parameter int DATA_W = 16;

    localparam int LIM_N     = 2 * VOLT_N + 2 + FAN_N;
    localparam int ADDR_CFG  = LIM_N;
    localparam int ADDR_STAT = LIM_N + 1;
    localparam int REG_AW    = $clog2(LIM_N + 2);
    localparam int A_TMAX    = 2 * VOLT_N;
    localparam int A_TMIN    = 2 * VOLT_N + 1;
    localparam int A_FAN0    = 2 * VOLT_N + 2;
    localparam int SHARED_CH = VOLT_N - 1;
    localparam int TEMP_BIT  = VOLT_N;
    localparam int FAN_BIT0  = VOLT_N + 1;
    localparam int EXT_BIT   = VOLT_N + 1 + FAN_N;
    localparam int STAT_W    = EXT_BIT + 1;

    typedef logic [CODE_W-1:0] code_t;

    function automatic code_t lim_reset(input int idx);
        if (idx < 2 * VOLT_N)
            return (idx % 2 == 0) ? '1 : '0;
        else if (idx == A_TMAX)
            return {1'b0, {(CODE_W-1){1'b1}}};
        else if (idx == A_TMIN)
            return {1'b1, {(CODE_W-1){1'b0}}};
        else
            return '0;
    endfunction
endpackage

// File: rtl/mon_limit_regs.sv
module mon_limit_regs
    import mon_alarm_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr,
    input  logic [REG_AW-1:0]            addr,
    input  logic [CODE_W-1:0]            wdata,
    output logic [LIM_N-1:0][CODE_W-1:0] lim,
    output logic                         share
);
    typedef struct packed {
        logic [LIM_N-1:0][CODE_W-1:0] lim;
        logic                         share;
    } lim_st_t;

    lim_st_t s_d, s_q;
    logic    unused_wdata;

    assign unused_wdata = ^wdata[CODE_W-1:1];

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < LIM_N; i++) begin
            if (wr && addr == REG_AW'(i))
                s_d.lim[i] = wdata;
        end
        if (wr && addr == REG_AW'(ADDR_CFG))
            s_d.share = wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LIM_N; i++)
                s_q.lim[i] <= lim_reset(i);
            s_q.share <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lim   = s_q.lim;
    assign share = s_q.share;
endmodule

// File: rtl/mon_volt_cmp.sv
module mon_volt_cmp
    import mon_alarm_pkg::*;
(
    input  code_t code,
    input  code_t max_lim,
    input  code_t min_lim,
    input  logic  en,
    output logic  hit
);
    always_comb begin
        hit = en && ((code > max_lim) || (code < min_lim));
    end
endmodule

// File: rtl/mon_temp_evt.sv
module mon_temp_evt
    import mon_alarm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  share,
    input  logic  vld,
    input  code_t code,
    input  code_t max_lim,
    input  code_t min_lim,
    output logic  evt
);
    logic armed_d, armed_q;

    always_comb begin
        armed_d = armed_q;
        evt     = 1'b0;
        if (!share) begin
            armed_d = 1'b0;
        end else if (vld) begin
            if (!armed_q && ($signed(code) > $signed(max_lim))) begin
                evt     = 1'b1;
                armed_d = 1'b1;
            end else if (armed_q && ($signed(code) < $signed(min_lim))) begin
                evt     = 1'b1;
                armed_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end
endmodule

// File: rtl/mon_alarm_reg.sv
module mon_alarm_reg
    import mon_alarm_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [VOLT_N*CODE_W-1:0] volt_code,
    input  logic [VOLT_N-1:0]        volt_vld,
    input  logic [FAN_N*CODE_W-1:0]  fan_code,
    input  logic [FAN_N-1:0]         fan_vld,
    input  logic                     ext_ovr,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [REG_AW-1:0]        reg_addr,
    input  logic [CODE_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata
);
    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [DATA_W-1:0] rdata;
    } top_st_t;

    top_st_t                      s_d, s_q;
    logic [LIM_N-1:0][CODE_W-1:0] lim;
    logic                         share_q;
    logic [STAT_W-1:0]            ev;
    logic [STAT_W-1:0]            stat_q;
    logic [DATA_W-1:0]            rd_mux;
    logic                         rd_stat;

    mon_limit_regs u_lim (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .lim   (lim),
        .share (share_q)
    );

    for (genvar i = 0; i < VOLT_N; i++) begin : g_volt
        logic en;
        if (i == SHARED_CH) begin : g_shared
            assign en = volt_vld[i] & ~share_q;
        end else begin : g_plain
            assign en = volt_vld[i];
        end
        mon_volt_cmp u_cmp (
            .code    (volt_code[i*CODE_W +: CODE_W]),
            .max_lim (lim[2*i]),
            .min_lim (lim[2*i+1]),
            .en      (en),
            .hit     (ev[i])
        );
    end

    mon_temp_evt u_temp (
        .clk     (clk),
        .rst_n   (rst_n),
        .share   (share_q),
        .vld     (volt_vld[SHARED_CH]),
        .code    (volt_code[SHARED_CH*CODE_W +: CODE_W]),
        .max_lim (lim[A_TMAX]),
        .min_lim (lim[A_TMIN]),
        .evt     (ev[TEMP_BIT])
    );

    for (genvar j = 0; j < FAN_N; j++) begin : g_fan
        assign ev[FAN_BIT0+j] = fan_vld[j] &&
                                (fan_code[j*CODE_W +: CODE_W] < lim[A_FAN0+j]);
    end

    assign ev[EXT_BIT] = ext_ovr;
    assign rd_stat     = reg_rd && (reg_addr == REG_AW'(ADDR_STAT));

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < LIM_N; i++) begin
            if (reg_addr == REG_AW'(i))
                rd_mux = DATA_W'(lim[i]);
        end
        if (reg_addr == REG_AW'(ADDR_CFG))
            rd_mux = DATA_W'(share_q);
        if (reg_addr == REG_AW'(ADDR_STAT))
            rd_mux = DATA_W'(s_q.stat);
    end

    always_comb begin
        s_d      = s_q;
        s_d.stat = (rd_stat ? '0 : s_q.stat) | ev;
        if (reg_rd)
            s_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stat_q    = s_q.stat;
    assign reg_rdata = s_q.rdata;
endmodule

module mon_alarm_chk
    import mon_alarm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ext_ovr,
    input logic              reg_rd,
    input logic [REG_AW-1:0] reg_addr,
    input logic [VOLT_N-1:0] volt_vld,
    input logic [FAN_N-1:0]  fan_vld,
    input logic [STAT_W-1:0] stat_q,
    input logic              share_q,
    input logic [DATA_W-1:0] reg_rdata
);
    logic rd_stat;
    assign rd_stat = reg_rd && (reg_addr == REG_AW'(ADDR_STAT));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    p_read_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> (reg_rdata == DATA_W'($past(stat_q))));

    p_ext_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ovr |=> stat_q[EXT_BIT]);

    p_shared_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (share_q && !stat_q[SHARED_CH]) |=> !stat_q[SHARED_CH]);

    p_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (volt_vld == '0 && fan_vld == '0 && !ext_ovr) |=>
        ((stat_q & ~$past(stat_q)) == '0));
endmodule

bind mon_alarm_reg mon_alarm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_ovr   (ext_ovr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .volt_vld  (volt_vld),
    .fan_vld   (fan_vld),
    .stat_q    (stat_q),
    .share_q   (share_q),
    .reg_rdata (reg_rdata)
);

// File: tb/sim_mon_alarm_reg.sv
`timescale 1ns/1ps
module sim_mon_alarm_reg;
    import mon_alarm_pkg::*;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [VOLT_N*CODE_W-1:0] volt_code = '0;
    logic [VOLT_N-1:0]        volt_vld = '0;
    logic [FAN_N*CODE_W-1:0]  fan_code = '0;
    logic [FAN_N-1:0]         fan_vld = '0;
    logic                     ext_ovr = 1'b0;
    logic                     reg_wr = 1'b0;
    logic                     reg_rd = 1'b0;
    logic [REG_AW-1:0]        reg_addr = '0;
    logic [CODE_W-1:0]        reg_wdata = '0;
    logic [DATA_W-1:0]        reg_rdata;

    int checks = 0;
    int errors = 0;
    logic [DATA_W-1:0] exp_q[$];
    string             tag_q[$];
    logic              rd_seen = 1'b0;

    localparam logic [REG_AW-1:0] ST = REG_AW'(15);

    always #10 clk = ~clk;

    mon_alarm_reg u0 (
        .clk(clk), .rst_n(rst_n), .volt_code(volt_code), .volt_vld(volt_vld),
        .fan_code(fan_code), .fan_vld(fan_vld), .ext_ovr(ext_ovr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always @(posedge clk) rd_seen <= reg_rd;

    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [DATA_W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (reg_rdata !== e) begin
                errors++;
                $display("FAIL %s: got %h expected %h", t, reg_rdata, e);
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = REG_AW'(a); reg_wdata = CODE_W'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, input int e, input string t);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = REG_AW'(a);
        exp_q.push_back(DATA_W'(e)); tag_q.push_back(t);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_ext(input int e, input string t);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = ST; ext_ovr = 1'b1;
        exp_q.push_back(DATA_W'(e)); tag_q.push_back(t);
        @(negedge clk);
        reg_rd = 1'b0; ext_ovr = 1'b0;
    endtask

    task automatic sv(input int ch, input int c);
        @(negedge clk);
        volt_code[ch*CODE_W +: CODE_W] = CODE_W'(c); volt_vld[ch] = 1'b1;
        @(negedge clk);
        volt_vld = '0;
    endtask

    task automatic sf(input int ch, input int c);
        @(negedge clk);
        fan_code[ch*CODE_W +: CODE_W] = CODE_W'(c); fan_vld[ch] = 1'b1;
        @(negedge clk);
        fan_vld = '0;
    endtask

    task automatic pulse_ext();
        @(negedge clk); ext_ovr = 1'b1;
        @(negedge clk); ext_ovr = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd(15, 'h000, "R1 status");
        rd(0, 'h0FF, "R1 volt max");
        rd(1, 'h000, "R1 volt min");
        rd(10, 'h07F, "R1 temp max");
        rd(11, 'h080, "R1 temp min");
        rd(14, 'h000, "R1 cfg");
        // R2 writes and readback
        wr(0, 'h80); wr(1, 'h20);
        rd(0, 'h080, "R2 readback max");
        rd(1, 'h020, "R2 readback min");
        // R3 voltage window
        sv(0, 'h50); rd(15, 'h000, "R3 in range");
        sv(0, 'h81); rd(15, 'h001, "R3 above max");
        rd(15, 'h000, "R7 cleared by read");
        sv(0, 'h80); rd(15, 'h000, "R3 equal max");
        sv(0, 'h20); rd(15, 'h000, "R3 equal min");
        sv(0, 'h1F); rd(15, 'h001, "R3 below min");
        // R7 sticky after cause gone
        sv(0, 'h81); sv(0, 'h50); rd(15, 'h001, "R7 sticky");
        rd(15, 'h000, "R7 clear again");
        // R9 no strobe
        @(negedge clk); volt_code[0 +: CODE_W] = 8'hFF; fan_code = '0;
        repeat (3) @(negedge clk);
        rd(15, 'h000, "R9 no strobe");
        // R5 fan
        wr(12, 'h40);
        sf(0, 'h3F); rd(15, 'h040, "R5 fan below");
        sf(0, 'h40); rd(15, 'h000, "R5 fan equal");
        // R6 external
        pulse_ext(); rd(15, 'h100, "R6 ext");
        // R7 event in read cycle
        rd_ext('h000, "R7 read with event");
        rd(15, 'h100, "R7 event kept");
        // R10 status write ignored
        pulse_ext(); wr(15, 'h00); rd(15, 'h100, "R10 status write");
        // R3 R5 simultaneous
        wr(3, 'h10); wr(13, 'h20);
        @(negedge clk);
        volt_code[CODE_W +: CODE_W] = 8'h05; volt_vld[1] = 1'b1;
        fan_code[CODE_W +: CODE_W] = 8'h00; fan_vld[1] = 1'b1;
        @(negedge clk); volt_vld = '0; fan_vld = '0;
        rd(15, 'h082, "R3 R5 two bits");
        // R8 shared input
        wr(8, 'h10);
        sv(4, 'h90); rd(15, 'h010, "R8 volt4 active");
        wr(14, 1); rd(14, 'h001, "R2 cfg readback");
        wr(10, 'h32); wr(11, 'h28);
        sv(4, 'h90); rd(15, 'h000, "R8 R4 volt4 off, unarmed low");
        sv(4, 'h33); rd(15, 'h020, "R4 rise above max");
        sv(4, 'h40); rd(15, 'h000, "R4 once per crossing");
        sv(4, 'h27); rd(15, 'h020, "R4 fall below min");
        sv(4, 'h10); rd(15, 'h000, "R4 disarmed low");
        sv(4, 'hF0); rd(15, 'h000, "R4 signed compare");
        sv(4, 'h33); rd(15, 'h020, "R4 rearm");
        wr(14, 0);
        sv(4, 'h90); rd(15, 'h010, "R8 back to volt4");
        wr(14, 1);
        sv(4, 'h20); rd(15, 'h000, "R8 armed cleared by mode");
        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2: got %0d pending reads expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule